// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog for a chip that must be pulled back into reset when its software stops running. Software controls it through a four-register write/read bus. A key register takes 16-bit command words. A divider-select register and a reload register set the timeout. A status register reports configuration updates that are still settling. A divider slows the block clock by a power of two. A 12-bit down-counter counts the divided ticks. When the counter runs out, a one-cycle reset request is raised and the count starts over from the reload value.

Control runs through a four-state machine that tracks two things: whether the watchdog has been started, and whether the configuration registers accept writes. The states are `ST_OFF_LOCKED`, `ST_OFF_OPEN`, `ST_RUN_LOCKED` and `ST_RUN_OPEN`. The transitions are:
- *start*: key 0xCCCC moves OFF to RUN and keeps the access setting.
- *unlock*: key 0x5555 moves LOCKED to OPEN.
- *lock*: key 0x0000 moves OPEN to LOCKED.
- *kick*: key 0xAAAA moves OPEN to LOCKED and reloads the counter.

No transition leads from RUN back to OFF. Each configuration register has a shadow copy, which software reads and writes, and an active copy, which the counter uses. The active copy takes the shadow value only after a fixed synchronisation delay.

Register addresses: 0 = key (reads 0), 1 = divider select (bits 2:0), 2 = reload (bits 11:0), 3 = status (bit 0 = divider update pending, bit 1 = reload update pending).

Top module: `key_watchdog`

## Requirements
- R1: After reset the divider select reads 0, the reload reads 0xFFF, the status reads 0, the key address reads 0, the counter holds 0xFFF, the block is stopped (`ST_OFF_LOCKED`) and `rst_req` is low.
- R2: Writing key 0xCCCC at clock edge E starts the block. With counter value C ≥ 1 and divide ratio D, `rst_req` is high for exactly the one cycle after edge E + C·D. The counter then reloads, so further pulses follow every reload·D cycles. While stopped, the counter never produces a request.
- R3: Writing key 0xAAAA at edge K loads the counter from the active reload value and restarts the divider, so the next request follows edge K + reload·D. This key also closes write access.
- R4: Writes to the divider select or reload register are ignored unless key 0x5555 has opened access. Key 0x0000 closes access again.
- R5: Divider select codes 0 to 6 give ratios 4, 8, 16, 32, 64, 128 and 256. Code 7 also gives 256.
- R6: The reload register keeps only bits 11:0 of a write. A reload value of 0 behaves as one divided tick.
- R7: An accepted write sets its status bit (bit 0 for the divider select, bit 1 for the reload) for SYNC_CYCLES cycles. The new value takes effect when the bit clears. A write to a register whose bit is set is ignored.
- R8: A key value other than 0xCCCC, 0xAAAA, 0x5555 and 0x0000 changes nothing.
- R9: Once started, no register write stops the block. Only reset returns it to `ST_OFF_LOCKED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; all logic is on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address for writes and reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A write sampled at edge W changes the readable shadow registers and the status bits in the cycle right after W. The status bit clears after edge W + SYNC_CYCLES. A reset request caused by a start at edge E or a kick at edge K is due one cycle after edge E + C·D or K + reload·D. The driver records the edge number of every key write and pushes each due edge number into a queue. A monitor samples `rst_req` on falling edges and compares the current edge count with the head of the queue, so a request that is early, late, missing or too long is reported. Register reads are checked on the falling edge after the write. For the status bit, the check is made at W + SYNC_CYCLES − 1, while it is still set, and again at W + SYNC_CYCLES, after it has cleared.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_OFF_LOCKED = 2'd0,
        ST_OFF_OPEN   = 2'd1,
        ST_RUN_LOCKED = 2'd2,
        ST_RUN_OPEN   = 2'd3
    } wdg_state_e;

    localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_KICK   = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_LOCK   = 16'h0000;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_RLD  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

endpackage

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              running,
    output logic              wr_open,
    output logic              start_pulse,
    output logic              kick_pulse
);

    wdg_state_e state_q, state_d;
    logic is_start, is_kick, is_unlock, is_lock;

    always_comb begin
        is_start  = key_wr && (key_val == KEY_START);
        is_kick   = key_wr && (key_val == KEY_KICK);
        is_unlock = key_wr && (key_val == KEY_UNLOCK);
        is_lock   = key_wr && (key_val == KEY_LOCK);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF_LOCKED: begin
                if (is_start)       state_d = ST_RUN_LOCKED;
                else if (is_unlock) state_d = ST_OFF_OPEN;
            end
            ST_OFF_OPEN: begin
                if (is_start)                state_d = ST_RUN_OPEN;
                else if (is_kick || is_lock) state_d = ST_OFF_LOCKED;
            end
            ST_RUN_LOCKED: begin
                if (is_unlock) state_d = ST_RUN_OPEN;
            end
            ST_RUN_OPEN: begin
                if (is_kick || is_lock) state_d = ST_RUN_LOCKED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        running     = 1'b0;
        wr_open     = 1'b0;
        unique case (state_q)
            ST_OFF_LOCKED: begin running = 1'b0; wr_open = 1'b0; end
            ST_OFF_OPEN:   begin running = 1'b0; wr_open = 1'b1; end
            ST_RUN_LOCKED: begin running = 1'b1; wr_open = 1'b0; end
            ST_RUN_OPEN:   begin running = 1'b1; wr_open = 1'b1; end
        endcase
        start_pulse = is_start && !running;
        kick_pulse  = is_kick;
    end

    // R9: no way back from a running state
    p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R3: a kick always leaves access closed
    p_kick_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY_KICK) |=> !wr_open);

    // R4: the unlock key always leaves access open
    p_unlock_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY_UNLOCK) |=> wr_open);

endmodule

// File: rtl/wdg_sync_reg.sv
module wdg_sync_reg #(
    parameter int         W           = 12,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter int         SYNC_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         open,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int BW = $clog2(SYNC_CYCLES + 1);

    logic [BW-1:0] busy_q;
    logic          accept;

    assign busy   = (busy_q != '0);
    assign accept = wr && open && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
            busy_q <= '0;
        end else if (accept) begin
            shadow <= wdata;
            busy_q <= BW'(SYNC_CYCLES);
        end else if (busy) begin
            busy_q <= busy_q - 1'b1;
            if (busy_q == BW'(1)) active <= shadow;
        end
    end

    // R7: a write during a pending update leaves the stored value alone
    p_busy_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> $stable(shadow));

    // R4: a write with access closed leaves the stored value alone
    p_locked_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !open) |=> $stable(shadow));

    // R7: when the pending flag drops, the counter sees the new value
    p_apply_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (active == shadow));

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
    parameter int CNT_W     = 12,
    parameter int CODE_W    = 3,
    parameter int BASE_LOG2 = 2,
    parameter int MAX_CODE  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              start,
    input  logic              kick,
    input  logic [CODE_W-1:0] div_code,
    input  logic [CNT_W-1:0]  reload,
    output logic              rst_req
);

    localparam int DIV_W = BASE_LOG2 + MAX_CODE;

    logic [DIV_W-1:0] pdiv_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_last;
    logic             tick;

    function automatic logic [DIV_W-1:0] last_count(input logic [CODE_W-1:0] code);
        int sh;
        sh = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return DIV_W'((1 << (BASE_LOG2 + sh)) - 1);
    endfunction

    assign div_last = last_count(div_code);
    assign tick     = running && (pdiv_q >= div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdiv_q  <= '0;
            cnt_q   <= '1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (kick) begin
                cnt_q  <= reload;
                pdiv_q <= '0;
            end else if (start) begin
                pdiv_q <= '0;
            end else if (tick) begin
                pdiv_q <= '0;
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_q   <= reload;
                    rst_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (running) begin
                pdiv_q <= pdiv_q + 1'b1;
            end
        end
    end

    // R2: the request lasts one cycle
    p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R2: a stopped watchdog never requests reset
    p_req_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> running);

    // R2: the divider holds still while stopped
    p_div_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start && !kick) |=> $stable(pdiv_q));

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import wdg_pkg::*;
#(
    parameter int SYNC_CYCLES = 4,
    parameter int RLD_W       = 12,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    logic running, wr_open, start_pulse, kick_pulse;
    logic key_wr, div_wr, rld_wr;
    logic [CODE_W-1:0] div_shadow, div_active;
    logic [RLD_W-1:0]  rld_shadow, rld_active;
    logic div_busy, rld_busy;

    assign key_wr = bus_wr && (bus_addr == ADDR_KEY);
    assign div_wr = bus_wr && (bus_addr == ADDR_DIV);
    assign rld_wr = bus_wr && (bus_addr == ADDR_RLD);

    wdg_key_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_val     (bus_wdata),
        .running     (running),
        .wr_open     (wr_open),
        .start_pulse (start_pulse),
        .kick_pulse  (kick_pulse)
    );

    wdg_sync_reg #(
        .W           (CODE_W),
        .RST_VAL     ('0),
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_div_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (div_wr),
        .open   (wr_open),
        .wdata  (bus_wdata[CODE_W-1:0]),
        .shadow (div_shadow),
        .active (div_active),
        .busy   (div_busy)
    );

    wdg_sync_reg #(
        .W           (RLD_W),
        .RST_VAL     ('1),
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_rld_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (rld_wr),
        .open   (wr_open),
        .wdata  (bus_wdata[RLD_W-1:0]),
        .shadow (rld_shadow),
        .active (rld_active),
        .busy   (rld_busy)
    );

    wdg_down_counter #(
        .CNT_W  (RLD_W),
        .CODE_W (CODE_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .start    (start_pulse),
        .kick     (kick_pulse),
        .div_code (div_active),
        .reload   (rld_active),
        .rst_req  (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_KEY:  bus_rdata = '0;
            ADDR_DIV:  bus_rdata = DATA_W'(div_shadow);
            ADDR_RLD:  bus_rdata = DATA_W'(rld_shadow);
            ADDR_STAT: bus_rdata = DATA_W'({rld_busy, div_busy});
        endcase
    end

endmodule

// File: tb/test_key_watchdog.sv
`timescale 1ns/1ps
module test_key_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    key_watchdog i_key_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // monitor: compare each reset request against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected rst_req at edge %0d (expected none)", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R2 rst_req at edge %0d, expected edge %0d", cyc, e);
                end
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        bus_addr = a;
        #0.5;
        check(int'(bus_rdata), exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int edge_no);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        edge_no = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle_until(input int edge_no);
        while (cyc < edge_no) @(negedge clk);
    endtask

    task automatic queue_drained(input string tag);
        check(exp_q.size(), 0, tag);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int w, w2, e, k, k2, k3, dmy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, 0, "R1 divider select after reset");
        rd(2'd2, 12'hFFF, "R1 reload after reset");
        rd(2'd3, 0, "R1 status after reset");
        rd(2'd0, 0, "R1 key address reads zero");
        check(int'(rst_req), 0, "R1 rst_req low after reset");

        // R8 unknown key neither starts nor unlocks
        wr(2'd0, 16'h1234, dmy);
        repeat (20) @(negedge clk);
        // R4 locked write ignored
        wr(2'd2, 16'd10, dmy);
        rd(2'd2, 12'hFFF, "R4 locked reload write ignored");
        rd(2'd3, 0, "R4 locked write sets no status");

        // R4 unlock, R7 pending flag timing and blocked write
        wr(2'd0, 16'h5555, dmy);
        wr(2'd2, 16'd11, w);
        rd(2'd3, 2, "R7 reload pending bit set");
        wr(2'd2, 16'd20, w2);
        rd(2'd2, 11, "R7 write during pending ignored");
        idle_until(w + 3);
        rd(2'd3, 2, "R7 bit still set at W+SYNC-1");
        idle_until(w + 4);
        rd(2'd3, 0, "R7 bit clear at W+SYNC");

        // R8 unknown key while open leaves access open; R6 width
        wr(2'd0, 16'hBEEF, dmy);
        wr(2'd2, 16'hF00A, w);
        rd(2'd2, 10, "R6 upper reload bits dropped / R8 access still open");
        idle_until(w + 5);
        // R4 lock key closes
        wr(2'd0, 16'h0000, dmy);
        wr(2'd2, 16'd5, dmy);
        rd(2'd2, 10, "R4 write after lock key ignored");

        // R3 kick while stopped: loads count, no request (R2)
        wr(2'd0, 16'hAAAA, dmy);
        repeat (60) @(negedge clk);
        queue_drained("R2 no request while stopped");

        // R2 start: C=10, D=4
        wr(2'd0, 16'hCCCC, e);
        exp_q.push_back(e + 40);
        exp_q.push_back(e + 80);
        idle_until(e + 82);
        queue_drained("R2 two periodic requests seen");

        // R3 kick restarts the count
        wr(2'd0, 16'hAAAA, k);
        exp_q.push_back(k + 40);
        idle_until(k + 41);
        queue_drained("R3 request after kick");

        // R9 stop attempts, then R5 code 7 with reload 2
        wr(2'd0, 16'h0000, dmy);
        wr(2'd0, 16'hCCCC, dmy);
        wr(2'd0, 16'h5555, dmy);
        wr(2'd1, 16'd7, w);
        rd(2'd3, 1, "R7 divider pending bit set");
        wr(2'd2, 16'd2, dmy);
        idle_until(w + 6);
        rd(2'd3, 0, "R7 both bits clear");
        wr(2'd0, 16'hAAAA, k2);
        exp_q.push_back(k2 + 512);
        exp_q.push_back(k2 + 1024);
        idle_until(k2 + 1025);
        queue_drained("R5 R9 code 7 divides by 256, still running");

        // R5 code 1 (ratio 8) and R6 reload 0 as one tick
        wr(2'd0, 16'h5555, dmy);
        wr(2'd1, 16'd1, w);
        wr(2'd2, 16'd0, dmy);
        idle_until(w + 6);
        wr(2'd0, 16'hAAAA, k3);
        exp_q.push_back(k3 + 8);
        exp_q.push_back(k3 + 16);
        exp_q.push_back(k3 + 24);
        // R3 kick closed access
        wr(2'd2, 16'd9, dmy);
        rd(2'd2, 0, "R3 kick closed write access");
        idle_until(k3 + 25);
        queue_drained("R5 R6 ratio 8 with reload 0");
        summary();
    end

endmodule